// File: doc/BRIEF.md
# Daisy-Chained Serial Codec Interface Node

This block is the serial-port logic of one converter node in a daisy chain of identical nodes. Words of 16 bits travel down the chain one hop per frame. Each frame starts with a one-cycle frame-sync pulse. A node copies its incoming frame sync to its outgoing frame sync one clock later, so the outgoing pulse of one node is the incoming pulse of the next. While it shifts a word in on its serial input, the node shifts its previously chosen word out on its serial output. The outgoing frame sync of the last node starts the host's transmit and receive.

After reset the node is in program mode. A control word that arrives with a zero address field is applied locally through a register write port. A control word with a nonzero address field is forwarded in the next frame with its address reduced by one, so a command reaches the node whose position matches the address. Data words received in program mode are dropped, and an invalid placeholder word is sent in their place. A write to the mode register moves the node into data mode and sets the cascade count. In data mode the node sends its own parallel sample first, then relays the words it receives from upstream for the rest of the sample period. It never applies a control word in data mode.

Top module: `ser_chain_node`

## Requirements
- R1: Synchronous active-high reset puts the node in program mode with a cascade count of one and a pending word of 0x0000. It also holds sdo, fs_out and wr_en low.
- R2: fs_out equals fs_in delayed by exactly one clock.
- R3: The outgoing word starts on sdo in the same cycle fs_out is high. It is sent MSB first over 16 consecutive cycles, and sdo is 0 after bit 0 until the next frame.
- R4: In program mode, a received control word (bit 15 = 1) with address field bits 14:12 = 0 gives a one-cycle wr_en pulse in the cycle after its last bit. wr_reg carries bits 11:8 and wr_data carries bits 7:0. The next frame sends the placeholder 0x0000.
- R5: In program mode, a received control word with a nonzero address is not written. The next frame sends the same word with its address field reduced by one and all other bits unchanged.
- R6: In program mode, a received data word (bit 15 = 0) is discarded, and the next frame sends the placeholder 0x0000.
- R7: A local write to register 0 loads the cascade count with wr_data bits 3:1 plus one. If wr_data bit 0 is 1, the node enters data mode; if it is 0, the node stays in program mode. Only reset leaves data mode.
- R8: In data mode, the first frame of each sample period sends sample_in as sampled in the fs_in cycle. The remaining count−1 frames each send the word received during the frame before.
- R9: In data mode, received control words cause no write, and the mode and cascade count stay unchanged. The words are only relayed.
- R10: A frame sync that arrives in the cycle right after the last bit of a word is accepted. The word just completed is routed in time to be sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fs_in | input | 1 | Frame sync from the upstream node or host |
| sdi | input | 1 | Serial data from upstream, MSB first |
| sample_in | input | 16 | Parallel sample of this node's converter |
| fs_out | output | 1 | Frame sync to the downstream node or host |
| sdo | output | 1 | Serial data to downstream, MSB first |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_reg | output | 4 | Register index of the last local write |
| wr_data | output | 8 | Data of the last local write |

## Verification
The bench builds the node with its default parameters: 16-bit words, a 3-bit address field, a 4-bit register index and a 3-bit cascade-count field. With these values it can drive the largest address, 7, down to 6 and test a cascade of one as well as a cascade of three. Back-to-back frames with no idle cycle check that forwarding keeps pace. A mode-register write with the mode bit clear, and control words sent after data mode is entered, check that only the right write changes the mode and the frame order.

// File: rtl/node_pkg.sv
package node_pkg;
  localparam int NODE_WORD_W = 16;
  localparam int NODE_ADDR_W = 3;
  localparam int NODE_REG_W  = 4;
  localparam int NODE_CNT_W  = 3;
  localparam int NODE_MODE_REG = 0;

  typedef enum logic {
    MODE_PROG = 1'b0,
    MODE_DATA = 1'b1
  } node_mode_e;
endpackage

// File: rtl/node_rx.sv
module node_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fs_in,
  input  logic         sdi,
  output logic         word_done,
  output logic [W-1:0] word_now
);
  localparam int CW = $clog2(W);

  logic [W-2:0] sr;
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (fs_in) begin
      sr     <= {sr[W-3:0], sdi};
      cnt    <= CW'(1);
      active <= 1'b1;
    end else if (active) begin
      sr <= {sr[W-3:0], sdi};
      if (cnt == CW'(W-1)) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign word_done = active && !fs_in && (cnt == CW'(W-1));
  assign word_now  = {sr, sdi};
endmodule

// File: rtl/node_tx.sv
module node_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         sdo
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
      sdo  <= 1'b0;
    end else if (load) begin
      sdo  <= load_word[W-1];
      sr   <= {load_word[W-2:0], 1'b0};
      left <= CW'(W-1);
    end else if (left != '0) begin
      sdo  <= sr[W-1];
      sr   <= {sr[W-2:0], 1'b0};
      left <= left - 1'b1;
    end else begin
      sdo <= 1'b0;
    end
  end
endmodule

// File: rtl/node_route.sv
module node_route
  import node_pkg::*;
#(
  parameter int          W        = NODE_WORD_W,
  parameter int          ADDR_W   = NODE_ADDR_W,
  parameter int          REG_W    = NODE_REG_W,
  parameter int          CNT_W    = NODE_CNT_W,
  parameter int          MODE_REG = NODE_MODE_REG,
  parameter logic [15:0] FILLER   = 16'h0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        word_done,
  input  logic [W-1:0]                word,
  output logic [W-1:0]                pend,
  output logic                        wr_en,
  output logic [REG_W-1:0]            wr_reg,
  output logic [W-2-ADDR_W-REG_W+1:0] wr_data,
  output logic                        data_mode,
  output logic [CNT_W-1:0]            cnt_m1
);
  localparam int CTL_BIT = W - 1;
  localparam int ADDR_LO = W - 1 - ADDR_W;
  localparam int REG_LO  = ADDR_LO - REG_W;
  localparam int DAT_W   = REG_LO;

  node_mode_e mode;

  logic [ADDR_W-1:0] f_addr;
  logic [ADDR_W-1:0] f_addr_dec;
  logic [REG_W-1:0]  f_reg;
  logic [DAT_W-1:0]  f_dat;
  logic [W-1:0]      fwd_word;

  always_comb begin
    f_addr     = word[CTL_BIT-1:ADDR_LO];
    f_addr_dec = f_addr - 1'b1;
    f_reg      = word[ADDR_LO-1:REG_LO];
    f_dat      = word[DAT_W-1:0];
    fwd_word   = {word[CTL_BIT], f_addr_dec, word[ADDR_LO-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= W'(FILLER);
      wr_en   <= 1'b0;
      wr_reg  <= '0;
      wr_data <= '0;
      mode    <= MODE_PROG;
      cnt_m1  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (word_done) begin
        if (mode == MODE_DATA) begin
          pend <= word;
        end else if (word[CTL_BIT]) begin
          if (f_addr == '0) begin
            wr_en   <= 1'b1;
            wr_reg  <= f_reg;
            wr_data <= f_dat;
            pend    <= W'(FILLER);
            if (f_reg == REG_W'(MODE_REG)) begin
              cnt_m1 <= f_dat[CNT_W:1];
              if (f_dat[0]) mode <= MODE_DATA;
            end
          end else begin
            pend <= fwd_word;
          end
        end else begin
          pend <= W'(FILLER);
        end
      end
    end
  end

  assign data_mode = (mode == MODE_DATA);
endmodule

// File: rtl/ser_chain_node.sv
module ser_chain_node
  import node_pkg::*;
#(
  parameter int W      = NODE_WORD_W,
  parameter int ADDR_W = NODE_ADDR_W,
  parameter int REG_W  = NODE_REG_W,
  parameter int CNT_W  = NODE_CNT_W,
  parameter int DAT_W  = W - 1 - ADDR_W - REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_in,
  input  logic             sdi,
  input  logic [W-1:0]     sample_in,
  output logic             fs_out,
  output logic             sdo,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_reg,
  output logic [DAT_W-1:0] wr_data
);
  logic             word_done;
  logic [W-1:0]     word_now;
  logic [W-1:0]     pend;
  logic             data_mode;
  logic [CNT_W-1:0] cnt_m1;
  logic [CNT_W-1:0] fidx;
  logic [W-1:0]     out_word;

  node_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .fs_in(fs_in), .sdi(sdi),
    .word_done(word_done), .word_now(word_now)
  );

  node_route #(
    .W(W), .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W),
    .MODE_REG(NODE_MODE_REG), .FILLER(16'h0000)
  ) u_route (
    .clk(clk), .rst(rst), .word_done(word_done), .word(word_now),
    .pend(pend), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .data_mode(data_mode), .cnt_m1(cnt_m1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fidx   <= '0;
      fs_out <= 1'b0;
    end else begin
      fs_out <= fs_in;
      if (fs_in && data_mode)
        fidx <= (fidx == cnt_m1) ? '0 : fidx + 1'b1;
    end
  end

  always_comb begin
    out_word = (data_mode && fidx == '0) ? sample_in : pend;
  end

  node_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .load(fs_in), .load_word(out_word), .sdo(sdo)
  );
endmodule

// File: rtl/node_chk.sv
module node_chk #(
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fs_in,
  input logic             fs_out,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_reg,
  input logic             data_mode
);
  assert_fs_relay_R2: assert property (@(posedge clk) disable iff (rst)
    fs_in |=> fs_out);
  assert_fs_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !fs_in |=> !fs_out);
  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  assert_mode_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(data_mode) |-> (wr_en && wr_reg == '0));
  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    data_mode |=> data_mode);
  assert_no_write_data_R9: assert property (@(posedge clk) disable iff (rst)
    data_mode |=> !wr_en);
endmodule

bind ser_chain_node node_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .fs_in(fs_in), .fs_out(fs_out),
  .wr_en(wr_en), .wr_reg(wr_reg), .data_mode(data_mode)
);

// File: tb/ser_chain_node_tb.sv
`timescale 1ns/1ps
module ser_chain_node_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, fs_in, sdi;
  logic [15:0] sample_in;
  logic        fs_out, sdo, wr_en;
  logic [3:0]  wr_reg;
  logic [7:0]  wr_data;

  ser_chain_node u_dut (
    .clk(clk), .rst(rst), .fs_in(fs_in), .sdi(sdi), .sample_in(sample_in),
    .fs_out(fs_out), .sdo(sdo), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  bit          m_data;
  int          m_cnt, m_fidx, m_txn, m_rxn;
  logic [15:0] m_pend, m_txw, m_rxw;
  logic        e_fs, e_sdo, e_wr;
  logic [3:0]  e_reg;
  logic [7:0]  e_dat;
  logic [15:0] cap;
  int          capn;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(int a, int r, logic [7:0] d);
    return {1'b1, 3'(a), 4'(r), d};
  endfunction

  task automatic model_reset();
    m_data = 0; m_cnt = 1; m_fidx = 0; m_pend = 16'h0; m_txw = 16'h0;
    m_txn = 0; m_rxn = 0; m_rxw = 16'h0;
    e_fs = 0; e_sdo = 0; e_wr = 0; e_reg = 0; e_dat = 0;
    cap = 16'h0; capn = 0;
  endtask

  task automatic model_word(logic [15:0] w);
    if (m_data) begin
      m_pend = w;
    end else if (w[15]) begin
      if (w[14:12] == 3'd0) begin
        e_wr = 1; e_reg = w[11:8]; e_dat = w[7:0]; m_pend = 16'h0;
        if (w[11:8] == 4'd0) begin
          m_cnt = int'(w[3:1]) + 1;
          if (w[0]) begin m_data = 1; m_fidx = 0; end
        end
      end else begin
        m_pend = {w[15], w[14:12] - 3'd1, w[11:0]};
      end
    end else begin
      m_pend = 16'h0;
    end
  endtask

  task automatic model_tick(bit f, bit d, logic [15:0] s);
    logic [15:0] w;
    e_fs = f; e_wr = 0;
    if (f) begin
      w = (m_data && m_fidx == 0) ? s : m_pend;
      if (m_data) m_fidx = (m_fidx == m_cnt - 1) ? 0 : m_fidx + 1;
      m_txw = w; m_txn = 15; e_sdo = w[15];
    end else if (m_txn > 0) begin
      e_sdo = m_txw[m_txn-1]; m_txn--;
    end else begin
      e_sdo = 0;
    end
    if (f) begin
      m_rxw = {15'b0, d}; m_rxn = 1;
    end else if (m_rxn > 0) begin
      m_rxw = {m_rxw[14:0], d}; m_rxn++;
      if (m_rxn == 16) begin m_rxn = 0; model_word(m_rxw); end
    end
  endtask

  task automatic step(bit f, bit d, logic [15:0] s);
    fs_in = f; sdi = d; sample_in = s;
    @(posedge clk); #1;
    model_tick(f, d, s);
    chk("R2 fs_out", fs_out, e_fs);
    chk("R3 sdo", sdo, e_sdo);
    chk("R4 wr_en", wr_en, e_wr);
    chk("R4 wr_reg", wr_reg, e_reg);
    chk("R4 wr_data", wr_data, e_dat);
    if (fs_out) begin cap = {15'b0, sdo}; capn = 1; end
    else if (capn > 0 && capn < 16) begin cap = {cap[14:0], sdo}; capn++; end
  endtask

  task automatic send(logic [15:0] w, logic [15:0] s, int gap);
    for (int i = 0; i < 16; i++) step(i == 0, w[15-i], s);
    for (int i = 0; i < gap; i++) step(0, 0, s);
  endtask

  task automatic do_reset();
    rst = 1; fs_in = 0; sdi = 0; sample_in = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sdo", sdo, 0);
    chk("R1 fs_out", fs_out, 0);
    chk("R1 wr_en", wr_en, 0);
    model_reset();
    rst = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, 0, 16'h0);

    // R4: local write, output is reset placeholder
    send(ctl(0, 5, 8'h3C), 16'hFFFF, 0);
    chk("R4 strobe", wr_en, 1);
    chk("R4 reg", wr_reg, 5);
    chk("R4 data", wr_data, 8'h3C);
    chk("R1 first word placeholder", cap, 16'h0);

    // R5: forwarded word is not written
    send(ctl(3, 2, 8'hA5), 16'hFFFF, 2);
    chk("R5 no write", wr_en, 0);
    chk("R4 placeholder after apply", cap, 16'h0);
    chk("R3 sdo idle after word", sdo, 0);

    send(ctl(7, 1, 8'h11), 16'hFFFF, 0);
    chk("R5 addr 3 to 2", cap, ctl(2, 2, 8'hA5));
    send(16'h1234, 16'hFFFF, 0);
    chk("R10 back-to-back addr 7 to 6", cap, ctl(6, 1, 8'h11));
    send(ctl(0, 0, 8'h04), 16'hFFFF, 1);
    chk("R6 data word discarded", cap, 16'h0);

    // R7: mode register with mode bit clear keeps program mode
    send(ctl(1, 3, 8'h03), 16'h9999, 0);
    send(ctl(0, 0, 8'h05), 16'h7777, 0);
    chk("R7 still program mode", cap, ctl(0, 3, 8'h03));
    chk("R7 mode write strobe", wr_en, 1);
    chk("R7 mode write data", wr_data, 8'h05);

    // R8 / R9: data mode, cascade of three
    send(16'hABCD, 16'h1234, 0);
    chk("R8 own sample first", cap, 16'h1234);
    send(ctl(0, 5, 8'h77), 16'h5555, 0);
    chk("R8 relay", cap, 16'hABCD);
    chk("R9 no write", wr_en, 0);
    send(16'h0F0F, 16'h6666, 0);
    chk("R9 control relayed", cap, ctl(0, 5, 8'h77));
    send(16'h2222, 16'hBEEF, 0);
    chk("R8 period wrap", cap, 16'hBEEF);
    chk("R9 reg kept", wr_reg, 0);
    chk("R9 data kept", wr_data, 8'h05);
    send(ctl(0, 0, 8'h00), 16'h1111, 0);
    chk("R8 relay second", cap, 16'h2222);
    send(16'h3333, 16'hAAAA, 0);
    chk("R9 mode word relayed", cap, ctl(0, 0, 8'h00));
    send(16'h4444, 16'hCCCC, 2);
    chk("R9 count kept", cap, 16'hCCCC);

    // R8: cascade of one
    do_reset();
    send(ctl(0, 0, 8'h01), 16'h0000, 0);
    send(16'h1357, 16'h2468, 0);
    chk("R8 count one sample", cap, 16'h2468);
    send(16'h5555, 16'h9ABC, 3);
    chk("R8 count one again", cap, 16'h9ABC);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule